// File: doc/BRIEF.md
# Format-Tracking Floating-Point Register File

This block holds the floating-point operand registers of a core. It has 32 entries. Each entry pairs a 64-bit data word with a tag that records how the data was last interpreted: single, word, double, long, paired-single, raw (uninterpreted) or unknown. The block has one read port and one write port. Each port carries a register index, a 4-bit format code and a width-mode bit, which selects either 64-bit registers or 32-bit registers.

A read whose format does not match the tag poisons the register. From then on, reads of that register return a canned quiet NaN for the format asked for. In 32-bit mode a 64-bit value is split across an even/odd register pair. An access that the mode cannot express raises a reserved-instruction pulse. A write whose format code is not recognised raises a fault pulse.

Reads are combinational. Read side effects (tag adoption and tag poisoning) and all writes commit on the rising clock edge.

Top module: `format_tracking_fprf`

## Requirements

Format codes: 0 single, 1 double, 2 word, 3 long, 4 paired-single, 5 raw, 6 raw-32, 7 raw-64. Codes 8 to 15 are unrecognised.

- R1: After reset, every register reads as zero with a raw request, and both flag outputs are low.
- R2: A committed read with a typed format (codes 0 to 4) of a register whose tag is a different typed format turns that tag to unknown. The read itself already returns the NaN for the requested format.
- R3: A read of an unknown-tagged register returns a quiet NaN for the requested format:
  - single: 0x7FBFFFFF
  - word: 0x7FFFFFFF
  - double: 0x7FF7FFFFFFFFFFFF
  - long: 0x7FFFFFFFFFFFFFFF
  - paired-single: 0x7FBFFFFF7FBFFFFF
- R4: A raw read (code 5) behaves as a read with the register's own tag. A raw-tagged register adopts the format of its first committed typed read, so a later read with another typed format returns the NaN.
- R5: In 64-bit mode, single and word reads return the low 32 bits, zero-extended. Double, long, paired-single and raw reads return all 64 bits.
- R6: In 64-bit mode, a single, word or raw-32 write stores the low 32 bits of the input and places 0xDEADC0DE in bits 63:32.
- R7: In 32-bit mode, a double, long, raw or raw-64 access to an even register n uses n for bits 31:0 and n+1 for bits 63:32. Both registers take the tag.
- R8: In 32-bit mode, these accesses raise reserved-instruction:
  - a double, long, raw or raw-64 access to an odd register;
  - any paired-single access.
  Such a write also tags the registers involved as unknown. An odd n affects n and n+1.
- R9: A raw-32 or raw-64 write stores its data and tags the register raw. A raw-64 write in 64-bit mode keeps all 64 bits.
- R10: An unrecognised write code tags the register unknown and raises the fault flag. A read with code 6 or higher, or a raw read of an unknown register, raises the fault flag and returns zero.
- R11: The reserved-instruction and fault flags are high for exactly the one cycle after the clock edge that commits the access.
- R12: When a read and a write target the same register in one cycle, the read returns the contents from before the edge, and the write's tag wins over the read's tag update.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en_i | input | 1 | Commit the read's tag side effects and flags at the edge |
| rd_idx_i | input | 5 | Read register index |
| rd_fmt_i | input | 4 | Read format code |
| rd_mode64_i | input | 1 | Read width mode: 1 selects 64-bit registers |
| rd_data_o | output | 64 | Combinational read data |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | 5 | Write register index |
| wr_fmt_i | input | 4 | Write format code |
| wr_mode64_i | input | 1 | Write width mode: 1 selects 64-bit registers |
| wr_data_i | input | 64 | Write data |
| resv_o | output | 1 | Reserved-instruction pulse |
| fault_o | output | 1 | Unrecognised-format pulse |

## Verification

The read port and the write port can land on the same register in the same cycle. The read's tag poisoning then competes with the write's new tag. The bench provokes this by writing a double, then issuing a committed single read and a single write to that register together. It judges the result by the NaN the read returns before the edge and by the clean single value that a later read returns, which shows the write's tag won. The same ordering is watched by an assertion on every double write.

// File: rtl/fprf_pkg.sv
package fprf_pkg;

  localparam int HALF_W = 32;
  localparam int FULL_W = 64;
  localparam int FMT_W  = 4;

  localparam logic [FMT_W-1:0] FC_SINGLE = 4'd0;
  localparam logic [FMT_W-1:0] FC_DOUBLE = 4'd1;
  localparam logic [FMT_W-1:0] FC_WORD   = 4'd2;
  localparam logic [FMT_W-1:0] FC_LONG   = 4'd3;
  localparam logic [FMT_W-1:0] FC_PAIRED = 4'd4;
  localparam logic [FMT_W-1:0] FC_RAW    = 4'd5;
  localparam logic [FMT_W-1:0] FC_RAW32  = 4'd6;
  localparam logic [FMT_W-1:0] FC_RAW64  = 4'd7;

  localparam logic [HALF_W-1:0] UPPER_FILL = 32'hDEADC0DE;

  typedef enum logic [2:0] {
    TG_RAW     = 3'd0,
    TG_SINGLE  = 3'd1,
    TG_DOUBLE  = 3'd2,
    TG_WORD    = 3'd3,
    TG_LONG    = 3'd4,
    TG_PAIRED  = 3'd5,
    TG_UNKNOWN = 3'd6
  } tag_t;

  // One pending change to a register: data and tag are enabled separately
  typedef struct packed {
    logic              data_en;
    logic              tag_en;
    logic [FULL_W-1:0] data;
    tag_t              tag;
  } upd_t;

  function automatic tag_t code_to_tag(input logic [FMT_W-1:0] c);
    case (c)
      FC_SINGLE: return TG_SINGLE;
      FC_DOUBLE: return TG_DOUBLE;
      FC_WORD:   return TG_WORD;
      FC_LONG:   return TG_LONG;
      FC_PAIRED: return TG_PAIRED;
      FC_RAW, FC_RAW32, FC_RAW64: return TG_RAW;
      default:   return TG_UNKNOWN;
    endcase
  endfunction

  function automatic logic is_half(input tag_t t);
    return (t == TG_SINGLE) || (t == TG_WORD);
  endfunction

  function automatic logic [FULL_W-1:0] quiet_nan(input tag_t t);
    case (t)
      TG_SINGLE: return 64'h0000_0000_7FBF_FFFF;
      TG_WORD:   return 64'h0000_0000_7FFF_FFFF;
      TG_DOUBLE: return 64'h7FF7_FFFF_FFFF_FFFF;
      TG_LONG:   return 64'h7FFF_FFFF_FFFF_FFFF;
      TG_PAIRED: return 64'h7FBF_FFFF_7FBF_FFFF;
      default:   return '0;
    endcase
  endfunction

endpackage

// File: rtl/fprf_read_port.sv
module fprf_read_port
  import fprf_pkg::*;
#(
  parameter int N_REGS = 32,
  parameter int IDX_W  = $clog2(N_REGS)
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [FMT_W-1:0]  fmt,
  input  logic              mode64,
  input  tag_t              tag_tbl  [N_REGS],
  input  logic [FULL_W-1:0] data_tbl [N_REGS],
  output logic [FULL_W-1:0] rdata,
  output logic              resv,
  output logic              fault,
  output upd_t              upd
);

  logic [IDX_W-1:0] pair_idx;
  tag_t cur, eff, nxt;
  logic legal;

  assign pair_idx = {idx[IDX_W-1:1], 1'b1};

  always_comb begin
    upd   = '0;
    rdata = '0;
    resv  = 1'b0;
    fault = 1'b0;
    cur   = tag_tbl[idx];
    legal = (fmt <= FC_RAW);
    eff   = (fmt == FC_RAW) ? cur : code_to_tag(fmt);
    nxt   = (cur == TG_RAW) ? eff : cur;
    if (eff != nxt) nxt = TG_UNKNOWN;
    if (!legal) begin
      fault = 1'b1;
    end else begin
      if (nxt != cur) begin
        upd.tag_en = 1'b1;
        upd.tag    = nxt;
      end
      if (nxt == TG_UNKNOWN) begin
        if (eff == TG_UNKNOWN) fault = 1'b1;
        else rdata = quiet_nan(eff);
      end else if (is_half(eff)) begin
        rdata = {{HALF_W{1'b0}}, data_tbl[idx][HALF_W-1:0]};
      end else if (mode64) begin
        rdata = data_tbl[idx];
      end else if (eff == TG_PAIRED || idx[0]) begin
        resv = 1'b1;
      end else begin
        rdata = {data_tbl[pair_idx][HALF_W-1:0], data_tbl[idx][HALF_W-1:0]};
      end
    end
  end

endmodule

// File: rtl/fprf_write_port.sv
module fprf_write_port
  import fprf_pkg::*;
#(
  parameter int N_REGS = 32,
  parameter int IDX_W  = $clog2(N_REGS)
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [FMT_W-1:0]  fmt,
  input  logic              mode64,
  input  logic [FULL_W-1:0] wdata,
  output upd_t              upd_a,
  output upd_t              upd_b,
  output logic [IDX_W-1:0]  idx_b,
  output logic              resv,
  output logic              fault
);

  localparam int LAST = N_REGS - 1;

  tag_t tg;
  logic has_partner;

  assign idx_b       = idx + 1'b1;
  assign has_partner = (int'(idx) < LAST);

  always_comb begin
    upd_a = '0;
    upd_b = '0;
    resv  = 1'b0;
    fault = 1'b0;
    tg    = code_to_tag(fmt);
    case (fmt)
      FC_SINGLE, FC_WORD, FC_RAW32: begin
        upd_a.data_en = 1'b1;
        upd_a.tag_en  = 1'b1;
        upd_a.tag     = tg;
        upd_a.data    = {mode64 ? UPPER_FILL : {HALF_W{1'b0}}, wdata[HALF_W-1:0]};
      end
      FC_DOUBLE, FC_LONG, FC_RAW, FC_RAW64: begin
        if (mode64) begin
          upd_a = '{data_en: 1'b1, tag_en: 1'b1, data: wdata, tag: tg};
        end else if (!idx[0]) begin
          upd_a = '{data_en: 1'b1, tag_en: 1'b1,
                    data: {{HALF_W{1'b0}}, wdata[HALF_W-1:0]}, tag: tg};
          upd_b = '{data_en: 1'b1, tag_en: 1'b1,
                    data: {{HALF_W{1'b0}}, wdata[FULL_W-1:HALF_W]}, tag: tg};
        end else begin
          upd_a.tag_en = 1'b1;
          upd_a.tag    = TG_UNKNOWN;
          upd_b.tag_en = has_partner;
          upd_b.tag    = TG_UNKNOWN;
          resv         = 1'b1;
        end
      end
      FC_PAIRED: begin
        if (mode64) begin
          upd_a = '{data_en: 1'b1, tag_en: 1'b1, data: wdata, tag: TG_PAIRED};
        end else begin
          upd_a.tag_en = 1'b1;
          upd_a.tag    = TG_UNKNOWN;
          resv         = 1'b1;
        end
      end
      default: begin
        upd_a.tag_en = 1'b1;
        upd_a.tag    = TG_UNKNOWN;
        fault        = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/fprf_bank.sv
module fprf_bank
  import fprf_pkg::*;
#(
  parameter int N_REGS = 32,
  parameter int IDX_W  = $clog2(N_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wa_idx,
  input  upd_t              wa,
  input  logic [IDX_W-1:0]  wb_idx,
  input  upd_t              wb,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  upd_t              ru,
  output tag_t              tag_tbl  [N_REGS],
  output logic [FULL_W-1:0] data_tbl [N_REGS]
);

  for (genvar i = 0; i < N_REGS; i++) begin : g_ent
    logic hit_a, hit_b, hit_r;
    assign hit_a = wr_en && (wa_idx == IDX_W'(i));
    assign hit_b = wr_en && (wb_idx == IDX_W'(i));
    assign hit_r = rd_en && (rd_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data_tbl[i] <= '0;
        tag_tbl[i]  <= TG_RAW;
      end else begin
        if (hit_a && wa.data_en)      data_tbl[i] <= wa.data;
        else if (hit_b && wb.data_en) data_tbl[i] <= wb.data;
        // write port has priority over the read's tag side effect
        if (hit_a && wa.tag_en)       tag_tbl[i] <= wa.tag;
        else if (hit_b && wb.tag_en)  tag_tbl[i] <= wb.tag;
        else if (hit_r && ru.tag_en)  tag_tbl[i] <= ru.tag;
      end
    end
  end

endmodule

// File: rtl/format_tracking_fprf.sv
module format_tracking_fprf
  import fprf_pkg::*;
#(
  parameter int N_REGS = 32,
  parameter int IDX_W  = $clog2(N_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [FMT_W-1:0]  rd_fmt_i,
  input  logic              rd_mode64_i,
  output logic [FULL_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [FMT_W-1:0]  wr_fmt_i,
  input  logic              wr_mode64_i,
  input  logic [FULL_W-1:0] wr_data_i,
  output logic              resv_o,
  output logic              fault_o
);

  tag_t              tag_tbl  [N_REGS];
  logic [FULL_W-1:0] data_tbl [N_REGS];

  upd_t             rd_upd, wr_upd_a, wr_upd_b;
  logic [IDX_W-1:0] wr_idx_b;
  logic             rd_resv, rd_fault, wr_resv, wr_fault;
  logic             resv_ev, fault_ev;

  fprf_read_port #(.N_REGS(N_REGS), .IDX_W(IDX_W)) u_rd (
    .idx(rd_idx_i), .fmt(rd_fmt_i), .mode64(rd_mode64_i),
    .tag_tbl(tag_tbl), .data_tbl(data_tbl),
    .rdata(rd_data_o), .resv(rd_resv), .fault(rd_fault), .upd(rd_upd)
  );

  fprf_write_port #(.N_REGS(N_REGS), .IDX_W(IDX_W)) u_wr (
    .idx(wr_idx_i), .fmt(wr_fmt_i), .mode64(wr_mode64_i), .wdata(wr_data_i),
    .upd_a(wr_upd_a), .upd_b(wr_upd_b), .idx_b(wr_idx_b),
    .resv(wr_resv), .fault(wr_fault)
  );

  fprf_bank #(.N_REGS(N_REGS), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en_i), .wa_idx(wr_idx_i), .wa(wr_upd_a),
    .wb_idx(wr_idx_b), .wb(wr_upd_b),
    .rd_en(rd_en_i), .rd_idx(rd_idx_i), .ru(rd_upd),
    .tag_tbl(tag_tbl), .data_tbl(data_tbl)
  );

  assign resv_ev  = (rd_en_i && rd_resv)  || (wr_en_i && wr_resv);
  assign fault_ev = (rd_en_i && rd_fault) || (wr_en_i && wr_fault);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_o  <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      resv_o  <= resv_ev;
      fault_o <= fault_ev;
    end
  end

endmodule

// File: rtl/fprf_checker.sv
module fprf_checker
  import fprf_pkg::*;
#(
  parameter int N_REGS = 32,
  parameter int IDX_W  = $clog2(N_REGS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en_i,
  input logic [IDX_W-1:0]  rd_idx_i,
  input logic [FMT_W-1:0]  rd_fmt_i,
  input logic [FULL_W-1:0] rd_data_o,
  input logic              wr_en_i,
  input logic [IDX_W-1:0]  wr_idx_i,
  input logic [FMT_W-1:0]  wr_fmt_i,
  input logic              wr_mode64_i,
  input logic              resv_o,
  input logic              fault_o,
  input tag_t              tag_tbl  [N_REGS],
  input logic [FULL_W-1:0] data_tbl [N_REGS]
);

  AST_FLAG_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (resv_o || fault_o) |-> $past(rd_en_i || wr_en_i)); // R11

  AST_UNKNOWN_SINGLE_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fmt_i == FC_SINGLE && tag_tbl[rd_idx_i] == TG_UNKNOWN)
      |-> rd_data_o == 64'h7FBFFFFF); // R3

  AST_MISMATCH_POISONS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !wr_en_i && rd_fmt_i < FC_RAW && tag_tbl[rd_idx_i] != TG_RAW
     && tag_tbl[rd_idx_i] != code_to_tag(rd_fmt_i))
      |=> tag_tbl[$past(rd_idx_i)] == TG_UNKNOWN); // R2

  AST_UPPER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_mode64_i && wr_fmt_i == FC_SINGLE)
      |=> data_tbl[$past(wr_idx_i)][FULL_W-1:HALF_W] == UPPER_FILL); // R6

  AST_BAD_CODE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_fmt_i > FC_RAW64)
      |=> fault_o && tag_tbl[$past(wr_idx_i)] == TG_UNKNOWN); // R10

  AST_ODD_PAIR_RESV: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_mode64_i && (wr_fmt_i == FC_DOUBLE || wr_fmt_i == FC_LONG)
     && wr_idx_i[0]) |=> resv_o); // R8

  AST_WRITE_TAG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_mode64_i && wr_fmt_i == FC_DOUBLE)
      |=> tag_tbl[$past(wr_idx_i)] == TG_DOUBLE); // R12

endmodule

bind format_tracking_fprf fprf_checker #(.N_REGS(N_REGS), .IDX_W(IDX_W)) u_fprf_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_en_i(rd_en_i), .rd_idx_i(rd_idx_i), .rd_fmt_i(rd_fmt_i), .rd_data_o(rd_data_o),
  .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_fmt_i(wr_fmt_i), .wr_mode64_i(wr_mode64_i),
  .resv_o(resv_o), .fault_o(fault_o),
  .tag_tbl(tag_tbl), .data_tbl(data_tbl)
);

// File: tb/test_format_tracking_fprf.sv
`timescale 1ns/1ps
module test_format_tracking_fprf;

  localparam logic [3:0] F_S = 4'd0, F_D = 4'd1, F_W = 4'd2, F_L = 4'd3,
                         F_PS = 4'd4, F_RAW = 4'd5, F_R32 = 4'd6, F_R64 = 4'd7;
  localparam logic [63:0] NAN_S = 64'h7FBFFFFF, NAN_W = 64'h7FFFFFFF,
                          NAN_D = 64'h7FF7FFFFFFFFFFFF, NAN_L = 64'h7FFFFFFFFFFFFFFF,
                          NAN_PS = {32'h7FBFFFFF, 32'h7FBFFFFF};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_en_i = 1'b0, rd_mode64_i = 1'b1, wr_en_i = 1'b0, wr_mode64_i = 1'b1;
  logic [4:0] rd_idx_i = '0, wr_idx_i = '0;
  logic [3:0] rd_fmt_i = '0, wr_fmt_i = '0;
  logic [63:0] wr_data_i = '0;
  logic [63:0] rd_data_o;
  logic resv_o, fault_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  format_tracking_fprf i_format_tracking_fprf (
    .clk(clk), .rst_n(rst_n),
    .rd_en_i(rd_en_i), .rd_idx_i(rd_idx_i), .rd_fmt_i(rd_fmt_i),
    .rd_mode64_i(rd_mode64_i), .rd_data_o(rd_data_o),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_fmt_i(wr_fmt_i),
    .wr_mode64_i(wr_mode64_i), .wr_data_i(wr_data_i),
    .resv_o(resv_o), .fault_o(fault_o)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_flags(input string req, input bit exp_resv, input bit exp_fault);
    chk({req, " resv"}, {63'd0, resv_o}, {63'd0, exp_resv});
    chk({req, " fault"}, {63'd0, fault_o}, {63'd0, exp_fault});
  endtask

  task automatic wr(input int idx, input logic [3:0] f, input bit m64, input logic [63:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = idx[4:0]; wr_fmt_i = f; wr_mode64_i = m64; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int idx, input logic [3:0] f, input bit m64, input bit commit,
                    output logic [63:0] q);
    @(negedge clk);
    rd_en_i = commit; rd_idx_i = idx[4:0]; rd_fmt_i = f; rd_mode64_i = m64;
    #1 q = rd_data_o;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [63:0] q;
    chk_flags("R1 reset flags", 1'b0, 1'b0);
    rd(3, F_RAW, 1'b1, 1'b0, q);  chk("R1 reg3 zero", q, 64'd0);
    rd(31, F_RAW, 1'b1, 1'b1, q); chk("R1 reg31 zero", q, 64'd0);
    chk_flags("R1 raw read flags", 1'b0, 1'b0);
  endtask

  task automatic t_wide_mode();
    logic [63:0] q;
    wr(2, F_S, 1'b1, 64'h11223344_AABBCCDD);
    rd(2, F_S, 1'b1, 1'b1, q);   chk("R5 single low half", q, 64'h00000000_AABBCCDD);
    wr(3, F_R32, 1'b1, 64'h99999999_01020304);
    rd(3, F_RAW, 1'b1, 1'b1, q); chk("R6 fill on raw-32", q, 64'hDEADC0DE_01020304);
    wr(6, F_D, 1'b1, 64'h01234567_89ABCDEF);
    rd(6, F_D, 1'b1, 1'b1, q);   chk("R5 double full", q, 64'h01234567_89ABCDEF);
    rd(6, F_L, 1'b1, 1'b1, q);   chk("R2 mismatch returns nan", q, NAN_L);
    rd(6, F_S, 1'b1, 1'b1, q);   chk("R3 single nan", q, NAN_S);
    rd(6, F_W, 1'b1, 1'b1, q);   chk("R3 word nan", q, NAN_W);
    rd(6, F_D, 1'b1, 1'b1, q);   chk("R2 poisoned double", q, NAN_D);
    rd(6, F_PS, 1'b1, 1'b1, q);  chk("R3 paired nan", q, NAN_PS);
    rd(6, F_RAW, 1'b1, 1'b1, q); chk("R10 raw read of unknown", q, 64'd0);
    chk_flags("R10 raw read of unknown", 1'b0, 1'b1);
    rd(2, F_R32, 1'b1, 1'b1, q); chk("R10 bad read code data", q, 64'd0);
    chk_flags("R10 bad read code", 1'b0, 1'b1);
  endtask

  task automatic t_adopt();
    logic [63:0] q;
    wr(9, F_R64, 1'b1, 64'hFEEDFACE_C0FFEE11);
    rd(9, F_RAW, 1'b1, 1'b1, q); chk("R9 raw-64 keeps all", q, 64'hFEEDFACE_C0FFEE11);
    rd(9, F_W, 1'b1, 1'b1, q);   chk("R4 first typed read", q, 64'h00000000_C0FFEE11);
    rd(9, F_W, 1'b1, 1'b1, q);   chk("R4 adopted word", q, 64'h00000000_C0FFEE11);
    rd(9, F_S, 1'b1, 1'b1, q);   chk("R4 other type after adopt", q, NAN_S);
  endtask

  task automatic t_pairs();
    logic [63:0] q;
    wr(4, F_D, 1'b0, 64'hCAFEF00D_12345678);
    chk_flags("R7 even pair write", 1'b0, 1'b0);
    rd(4, F_D, 1'b0, 1'b1, q);   chk("R7 pair reassembled", q, 64'hCAFEF00D_12345678);
    rd(4, F_D, 1'b1, 1'b1, q);   chk("R7 low reg holds low", q, 64'h00000000_12345678);
    rd(5, F_D, 1'b1, 1'b1, q);   chk("R7 high reg holds high", q, 64'h00000000_CAFEF00D);
    rd(5, F_D, 1'b0, 1'b1, q);
    chk_flags("R8 odd read", 1'b1, 1'b0);
    @(negedge clk);
    chk_flags("R11 pulse ends", 1'b0, 1'b0);
    wr(11, F_L, 1'b0, 64'h5555AAAA_5555AAAA);
    chk_flags("R8 odd write", 1'b1, 1'b0);
    rd(11, F_S, 1'b1, 1'b1, q);  chk("R8 odd reg unknown", q, NAN_S);
    chk_flags("R11 one cycle only", 1'b0, 1'b0);
    rd(12, F_W, 1'b1, 1'b1, q);  chk("R8 partner unknown", q, NAN_W);
    wr(14, F_PS, 1'b0, 64'h1);
    chk_flags("R8 paired write narrow", 1'b1, 1'b0);
    rd(14, F_D, 1'b1, 1'b1, q);  chk("R8 paired write poisons", q, NAN_D);
    rd(16, F_PS, 1'b0, 1'b1, q);
    chk_flags("R8 paired read narrow", 1'b1, 1'b0);
  endtask

  task automatic t_bad_code();
    logic [63:0] q;
    wr(20, F_D, 1'b1, 64'h0BADBEEF_0BADBEEF);
    wr(20, 4'd9, 1'b1, 64'h1);
    chk_flags("R10 bad write code", 1'b0, 1'b1);
    rd(20, F_D, 1'b1, 1'b1, q);  chk("R10 tag unknown", q, NAN_D);
  endtask

  task automatic t_same_cycle();
    logic [63:0] q;
    wr(22, F_D, 1'b1, 64'hAAAA0000_BBBB1111);
    @(negedge clk);
    rd_en_i = 1'b1; rd_idx_i = 5'd22; rd_fmt_i = F_S; rd_mode64_i = 1'b1;
    wr_en_i = 1'b1; wr_idx_i = 5'd22; wr_fmt_i = F_S; wr_mode64_i = 1'b1;
    wr_data_i = 64'h0_76543210;
    #1 chk("R12 read sees old state", rd_data_o, NAN_S);
    @(negedge clk);
    rd_en_i = 1'b0; wr_en_i = 1'b0;
    rd(22, F_S, 1'b1, 1'b1, q);  chk("R12 write tag wins", q, 64'h0_76543210);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wide_mode();
    t_adopt();
    t_pairs();
    t_bad_code();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule